// File: doc/BRIEF.md
# Amplifier Channel Control and Status Registers

This block is the register front end for one analog amplifier channel. A bus master reaches it through a simple APB-style slave port, always ready, with no wait states. It holds four word registers. Their fields drive the amplifier enable, the digital buffer enable and the calibration reference selection out to the analog side.

The amplifier's digital comparator output arrives asynchronously. It passes through a two-flop synchronizer into the bus clock domain. While the buffer is enabled, a flag records every change of that output, in either direction. Software clears the flag by writing one to it. The flag, together with an enable bit, drives an interrupt request.

A small handshake drives an external calibration engine. A trigger write is accepted only while the amplifier is enabled. It sends a one-cycle start pulse, marks the channel busy and clears the done status. The engine's done pulse ends the busy state and latches the two pass/fail results.

Top module: `amp_regctl`

## Requirements
- R1: After reset, the registers at word offsets 0x0, 0x4 and 0x8 read 0. The register at 0xC reads 0x1, with done set. irq_o is 0.
- R2: The control register at 0x0 holds the amplifier enable at bit 0, the buffer enable at bit 4 and the interrupt enable at bit 8. These bits read back as written and drive amp_en_o and buf_en_o. All other bits read 0.
- R3: Status bit 0 at 0x4 returns the synchronized amp_dout_i while the buffer enable is 1, and reads 0 while the buffer enable is 0.
- R4: Status bit 4 is set by every rising or falling change of the synchronized output while the buffer enable is 1. Changes while the buffer is disabled do not set it. Turning the buffer enable on does not set it.
- R5: Writing 1 to status bit 4 clears the flag. Writing 0 there leaves the flag unchanged.
- R6: irq_o is 1 exactly when the flag and the interrupt enable are both 1, with one cycle of register delay.
- R7: Writing 1 to bit 0 at 0x8 while the amplifier enable is 1 does three things. Bit 0 then reads 1. cal_start_o pulses high for exactly one cycle. Done (bit 0 at 0xC) reads 0.
- R8: Writing 1 to bit 0 at 0x8 while the amplifier enable is 0 is ignored. The trigger bit stays 0, no start pulse is sent and done is unchanged.
- R9: A cal_done_i pulse during a calibration clears the trigger bit and sets done. In the same cycle it latches cal_fail_n_i into bit 1 and cal_fail_p_i into bit 2 at 0xC, where 1 means fail. A done pulse with no calibration in progress changes nothing.
- R10: Bit 16 at 0x8 reads back as written and drives cal_ref_sel_o. 0 selects the half-supply reference and 1 selects the high-to-low common-mode sweep.
- R11: The register at 0xC is read-only. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address; bits 3:2 pick the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, captured in the setup phase |
| amp_dout_i | input | 1 | Asynchronous comparator output of the amplifier |
| amp_en_o | output | 1 | Amplifier enable |
| buf_en_o | output | 1 | Schmitt buffer enable |
| cal_start_o | output | 1 | One-cycle calibration start pulse |
| cal_ref_sel_o | output | 1 | Calibration reference mode |
| cal_done_i | input | 1 | Calibration engine finish pulse |
| cal_fail_n_i | input | 1 | NMOS result, 1 means fail |
| cal_fail_p_i | input | 1 | PMOS result, 1 means fail |
| irq_o | output | 1 | Interrupt request |

## Verification
The comparator path is driven with a seeded random sequence of output levels. Some steps repeat the previous level and some flip it, so the bench can tell a real change from a mere sample. Random write-one and write-zero accesses to the flag separate a true clear from a no-op write. Directed cases toggle the input with the buffer off, and turn the buffer on while the input is already high. These show that gating both blanks the level and suppresses edges, including the false edge at enable time. Calibration runs are tried with the amplifier off and on, with both result polarities, and with a stray done pulse while idle. These tell an accepted trigger from an ignored one, and a latched result from a spurious one.

// File: rtl/amp_regctl_pkg.sv
package amp_regctl_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_LSB = 2;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_CCTL  = 2'd2,
    REG_CSTAT = 2'd3
  } reg_sel_e;

  localparam int CTRL_AEN   = 0;
  localparam int CTRL_BEN   = 4;
  localparam int CTRL_IEN   = 8;
  localparam int STAT_LVL   = 0;
  localparam int STAT_FLAG  = 4;
  localparam int CCTL_TRIG  = 0;
  localparam int CCTL_REF   = 16;
  localparam int CSTAT_DONE = 0;
  localparam int CSTAT_NF   = 1;
  localparam int CSTAT_PF   = 2;
endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/amp_edge_flag.sv
module amp_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  input  logic enable,
  input  logic clr,
  output logic level,
  output logic flag
);
  logic prev_q;
  logic flag_q;
  logic edge_hit;

  // prev tracks the raw synchronized value even while gated, so enabling
  // the buffer never compares against a stale level
  assign edge_hit = enable & (sig ^ prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sig;
      flag_q <= edge_hit | (flag_q & ~clr);
    end
  end

  assign level = enable & sig;
  assign flag  = flag_q;
endmodule

// File: rtl/amp_cal_ctl.sv
module amp_cal_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic amp_en,
  input  logic eng_done,
  input  logic eng_fail_n,
  input  logic eng_fail_p,
  output logic busy,
  output logic start,
  output logic done,
  output logic res_n,
  output logic res_p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      start <= 1'b0;
      done  <= 1'b1;
      res_n <= 1'b0;
      res_p <= 1'b0;
    end else begin
      start <= 1'b0;
      if (busy && eng_done) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        res_n <= eng_fail_n;
        res_p <= eng_fail_p;
      end else if (req && amp_en && !busy) begin
        busy  <= 1'b1;
        start <= 1'b1;
        done  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/amp_regctl.sv
module amp_regctl
  import amp_regctl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              amp_dout_i,
  output logic              amp_en_o,
  output logic              buf_en_o,
  output logic              cal_start_o,
  output logic              cal_ref_sel_o,
  input  logic              cal_done_i,
  input  logic              cal_fail_n_i,
  input  logic              cal_fail_p_i,
  output logic              irq_o
);
  logic     wr_en, rd_cap;
  reg_sel_e sel;
  logic     amp_en_q, buf_en_q, irq_en_q, ref_q;
  logic     sync_w, level_w, flag_w;
  logic     cal_busy_w, cal_done_w, res_n_w, res_p_w;
  logic     irq_q;
  logic [DATA_W-1:0] rd_word, prdata_q;
  logic     unused_bits;

  assign wr_en  = psel & penable & pwrite;
  assign rd_cap = psel & ~penable & ~pwrite;
  assign sel    = reg_sel_e'(paddr[SEL_LSB +: 2]);
  assign unused_bits = ^{paddr, pwdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_en_q <= 1'b0;
      buf_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      ref_q    <= 1'b0;
    end else if (wr_en) begin
      if (sel == REG_CTRL) begin
        amp_en_q <= pwdata[CTRL_AEN];
        buf_en_q <= pwdata[CTRL_BEN];
        irq_en_q <= pwdata[CTRL_IEN];
      end
      if (sel == REG_CCTL) ref_q <= pwdata[CCTL_REF];
    end
  end

  amp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (amp_dout_i),
    .q   (sync_w)
  );

  amp_edge_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .sig    (sync_w),
    .enable (buf_en_q),
    .clr    (wr_en && sel == REG_STAT && pwdata[STAT_FLAG]),
    .level  (level_w),
    .flag   (flag_w)
  );

  amp_cal_ctl u_cal (
    .clk        (clk),
    .rst        (rst),
    .req        (wr_en && sel == REG_CCTL && pwdata[CCTL_TRIG]),
    .amp_en     (amp_en_q),
    .eng_done   (cal_done_i),
    .eng_fail_n (cal_fail_n_i),
    .eng_fail_p (cal_fail_p_i),
    .busy       (cal_busy_w),
    .start      (cal_start_o),
    .done       (cal_done_w),
    .res_n      (res_n_w),
    .res_p      (res_p_w)
  );

  always_comb begin
    rd_word = '0;
    case (sel)
      REG_CTRL: begin
        rd_word[CTRL_AEN] = amp_en_q;
        rd_word[CTRL_BEN] = buf_en_q;
        rd_word[CTRL_IEN] = irq_en_q;
      end
      REG_STAT: begin
        rd_word[STAT_LVL]  = level_w;
        rd_word[STAT_FLAG] = flag_w;
      end
      REG_CCTL: begin
        rd_word[CCTL_TRIG] = cal_busy_w;
        rd_word[CCTL_REF]  = ref_q;
      end
      default: begin
        rd_word[CSTAT_DONE] = cal_done_w;
        rd_word[CSTAT_NF]   = res_n_w;
        rd_word[CSTAT_PF]   = res_p_w;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (rd_cap) prdata_q <= rd_word;
      irq_q <= flag_w & irq_en_q;
    end
  end

  assign prdata        = prdata_q;
  assign irq_o         = irq_q;
  assign amp_en_o      = amp_en_q;
  assign buf_en_o      = buf_en_q;
  assign cal_ref_sel_o = ref_q;
endmodule

// File: rtl/amp_regctl_chk.sv
module amp_regctl_chk (
  input logic clk,
  input logic rst,
  input logic amp_en_o,
  input logic buf_en_o,
  input logic cal_start_o,
  input logic cal_done_i,
  input logic irq_o,
  input logic flag_w,
  input logic irq_en_q,
  input logic cal_busy_w,
  input logic cal_done_w
);
  assert_flag_gated_R4: assert property (@(posedge clk) disable iff (rst)
    !buf_en_o |=> !$rose(flag_w));

  assert_irq_follow_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(flag_w && irq_en_q));

  assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |=> !cal_start_o);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_start_o) |-> (cal_busy_w && !cal_done_w));

  assert_no_start_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!amp_en_o && !cal_busy_w) |=> !cal_start_o);

  assert_finish_R9: assert property (@(posedge clk) disable iff (rst)
    (cal_done_i && cal_busy_w) |=> (cal_done_w && !cal_busy_w));
endmodule

bind amp_regctl amp_regctl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .amp_en_o    (amp_en_o),
  .buf_en_o    (buf_en_o),
  .cal_start_o (cal_start_o),
  .cal_done_i  (cal_done_i),
  .irq_o       (irq_o),
  .flag_w      (flag_w),
  .irq_en_q    (irq_en_q),
  .cal_busy_w  (cal_busy_w),
  .cal_done_w  (cal_done_w)
);

// File: tb/amp_regctl_bench.sv
`timescale 1ns/1ps
module amp_regctl_bench;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_CCTL = 4'h8, A_CSTAT = 4'hC;

  logic clk = 1'b0, rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic amp_dout_i = 0, cal_done_i = 0, cal_fail_n_i = 0, cal_fail_p_i = 0;
  logic amp_en_o, buf_en_o, cal_start_o, cal_ref_sel_o, irq_o;

  int n_checks = 0, n_fails = 0, start_cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  amp_regctl #(.ADDR_W(AW)) u_amp_regctl (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .amp_dout_i(amp_dout_i),
    .amp_en_o(amp_en_o), .buf_en_o(buf_en_o), .cal_start_o(cal_start_o),
    .cal_ref_sel_o(cal_ref_sel_o), .cal_done_i(cal_done_i),
    .cal_fail_n_i(cal_fail_n_i), .cal_fail_p_i(cal_fail_p_i), .irq_o(irq_o)
  );

  always @(negedge clk) if (cal_start_o === 1'b1) start_cycles++;

  function automatic logic [31:0] stat_word(input logic lvl, input logic flg);
    return {27'd0, flg, 3'd0, lvl};
  endfunction

  function automatic logic [31:0] cstat_word(input logic dn, input logic nf, input logic pf);
    return {29'd0, pf, nf, dn};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
    d = prdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic eng_done(input logic nf, input logic pf);
    @(negedge clk); cal_done_i = 1; cal_fail_n_i = nf; cal_fail_p_i = pf;
    @(negedge clk); cal_done_i = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic lvl_m, flg_m, prev_in;
    int sc;
    void'($urandom(32'd7331));
    idle(5);
    @(negedge clk) rst = 0;
    idle(2);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v);  chk("R1 stat", v, 32'h0);
    rd(A_CCTL, v);  chk("R1 cctl", v, 32'h0);
    rd(A_CSTAT, v); chk("R1 cstat", v, cstat_word(1, 0, 0));
    chk("R1 irq", {31'd0, irq_o}, 32'h0);

    // R2 field readback
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 readback", v, 32'h111);
    chk("R2 outputs", {30'd0, amp_en_o, buf_en_o}, 32'h3);

    // R3/R4: buffer off blanks level and edges
    wr(A_CTRL, 32'h001);
    amp_dout_i = 1; idle(6);
    rd(A_STAT, v); chk("R3 gated level", v, stat_word(0, 0));
    chk("R4 no flag while off", v, stat_word(0, 0));
    // R4: enabling with input high creates no edge
    wr(A_CTRL, 32'h011); idle(4);
    rd(A_STAT, v); chk("R4 enable no spurious edge", v, stat_word(1, 0));

    // random level sequence, R3 R4 R5 R6
    wr(A_CTRL, 32'h111);
    prev_in = 1; flg_m = 0;
    for (int i = 0; i < 40; i++) begin
      lvl_m = 1'($urandom_range(0, 1));
      amp_dout_i = lvl_m;
      if (lvl_m != prev_in) flg_m = 1;
      prev_in = lvl_m;
      idle(5);
      rd(A_STAT, v); chk("R3 R4 random level/flag", v, stat_word(lvl_m, flg_m));
      chk("R6 irq follows flag", {31'd0, irq_o}, {31'd0, flg_m});
      if ($urandom_range(0, 1) == 1) begin
        wr(A_STAT, 32'h10); flg_m = 0;
      end else begin
        wr(A_STAT, 32'h0);
      end
      idle(2);
      rd(A_STAT, v); chk("R5 w1c / write-zero", v, stat_word(lvl_m, flg_m));
    end

    // R4 edges while disabled ignored
    wr(A_STAT, 32'h10);
    wr(A_CTRL, 32'h101);
    amp_dout_i = ~amp_dout_i; idle(5);
    amp_dout_i = ~amp_dout_i; idle(5);
    rd(A_STAT, v); chk("R4 toggles while off", v, stat_word(0, 0));
    chk("R6 irq low no flag", {31'd0, irq_o}, 32'h0);

    // R6 irq masked
    wr(A_CTRL, 32'h011);
    amp_dout_i = ~amp_dout_i; idle(5);
    rd(A_STAT, v); chk("R4 flag set", v[4], 1'b1);
    chk("R6 irq masked", {31'd0, irq_o}, 32'h0);
    wr(A_CTRL, 32'h111); idle(2);
    chk("R6 irq unmasked", {31'd0, irq_o}, 32'h1);

    // R8 trigger ignored with amplifier off
    wr(A_CTRL, 32'h010);
    sc = start_cycles;
    wr(A_CCTL, 32'h1);
    rd(A_CCTL, v);  chk("R8 trigger stays 0", v, 32'h0);
    chk("R8 no start pulse", start_cycles, sc);
    rd(A_CSTAT, v); chk("R8 done unchanged", v, cstat_word(1, 0, 0));

    // R7 R10 accepted trigger
    wr(A_CTRL, 32'h001);
    sc = start_cycles;
    wr(A_CCTL, 32'h1_0001);
    rd(A_CCTL, v);  chk("R7 R10 cctl busy+ref", v, 32'h1_0001);
    chk("R10 ref output", {31'd0, cal_ref_sel_o}, 32'h1);
    chk("R7 single-cycle start", start_cycles, sc + 1);
    rd(A_CSTAT, v); chk("R7 done cleared", v, cstat_word(0, 0, 0));
    // R7 retrigger while busy gives no extra pulse
    wr(A_CCTL, 32'h1_0001);
    chk("R7 no restart while busy", start_cycles, sc + 1);

    // R9 finish with NMOS fail
    eng_done(1, 0);
    rd(A_CCTL, v);  chk("R9 trigger cleared", v, 32'h1_0000);
    rd(A_CSTAT, v); chk("R9 results n-fail", v, cstat_word(1, 1, 0));

    // R11 read-only
    wr(A_CSTAT, 32'h0);
    rd(A_CSTAT, v); chk("R11 cstat read-only", v, cstat_word(1, 1, 0));

    // second run, ref 0, PMOS fail
    wr(A_CCTL, 32'h1);
    chk("R10 ref cleared", {31'd0, cal_ref_sel_o}, 32'h0);
    eng_done(0, 1);
    rd(A_CSTAT, v); chk("R9 results p-fail", v, cstat_word(1, 0, 1));
    // R9 stray done while idle
    eng_done(1, 1);
    rd(A_CSTAT, v); chk("R9 idle done ignored", v, cstat_word(1, 0, 1));

    idle(4);
    summary();
  end
endmodule